// File: doc/BRIEF.md
# ADPCM Serial Word Packer

This block takes the four channel codes produced by a bank of ADPCM encoders and serialises them onto one shared ADPCM output line. Each code is four bits wide. The most significant bit is the first bit that goes out on the wire. The encoder mode select sets how wide each word is on the wire:

- four bits at 32 kbit/s;
- three bits plus a zero pad at 24 kbit/s;
- two bits at 16 kbit/s, where all four channels share one octet.

The mode select also covers the bypass codes, an algorithm-reset code and a disable code. A data-valid output models the enable of a tristate driver. When it is low, the line is meant to float, and the data bit is held at zero.

Framing comes from outside the block. A one-cycle frame strobe latches the mode, the slot select and all four codes. After that, two eight-bit timeslot enables mark where the first and second octets go out. One bit leaves per bit-clock cycle while an enable is high. In the nibble formats, channels 1 and 2 share the first octet and channels 3 and 4 share the second. In the packed formats, the slot select picks which timeslot carries the single octet.

The control state machine has four states:

- ST_IDLE: entered after reset; nothing is driven.
- ST_READY: a frame has been latched and the block waits for a timeslot.
- ST_SLOT1: the block is shifting the first octet.
- ST_SLOT2: the block is shifting the second octet.

The transitions are:

- The frame strobe moves any state to ST_READY and clears the bit counter.
- An active first enable enters or stays in ST_SLOT1.
- An active second enable enters or stays in ST_SLOT2.
- A cycle with no enable returns ST_SLOT1 or ST_SLOT2 to ST_READY.
- ST_IDLE stays put until the first frame strobe.

Top module: `adpcm_word_packer`

## Requirements
- R1: After reset, `ser_oe` and `ser_data` are 0. They stay 0, even while the enables are pulsed, until the first frame strobe.
- R2: `enc_mode` and `pack_sel` are sampled only in a cycle with `frame_strobe` high. A change between strobes has no effect on the current frame.
- R3: Mode 000 (32 kbit/s) sends channel 1's code then channel 2's code in slot 1, and channel 3's then channel 4's in slot 2. Each code goes out bit 3 first. Channel k's code is `ch_codes[4k-1:4k-4]`.
- R4: Mode 001 (24 kbit/s) has the same layout as R3. Each nibble carries code bits 3, 2 and 1, and then a 0 in the fourth position.
- R5: Mode 010 (16 kbit/s) sends one octet. It holds code bits 3 and 2 of channel 1 in octet bits 7:6, then channel 2, then channel 3, then channel 4 in bits 1:0. The octet goes in slot 1 when the latched select is 0 and in slot 2 when it is 1. During the other slot, `ser_oe` stays 0.
- R6: Mode 011 (bypass, 32/24) uses the R3 layout. Mode 100 (bypass, 16) uses the R5 layout and its slot choice.
- R7: Mode 110 (algorithm reset) drives `ser_oe` high with `ser_data` 0 for all bits of both slots.
- R8: Mode 111 (output disable) and mode 101 (PCM bypass) keep `ser_oe` at 0 in both slots.
- R9: An output bit appears on the cycle after the clock edge that samples its enable. `ser_oe` is 0 after any cycle with no enable or with a frame strobe. `ser_data` is 0 whenever `ser_oe` is 0. Each time an enable rises, the octet restarts at bit 7.
- R10: The channel codes are captured at the frame strobe. Later changes to `ch_codes` do not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_strobe | input | 1 | One-cycle frame start; latches mode, select and codes |
| slot1_en | input | 1 | First timeslot enable, high for eight bit clocks |
| slot2_en | input | 1 | Second timeslot enable, high for eight bit clocks |
| pack_sel | input | 1 | Picks the timeslot for the packed 16 kbit/s octet |
| enc_mode | input | 3 | Encoder mode code |
| ch_codes | input | 16 | Four 4-bit channel codes, channel 1 in bits 3:0 |
| ser_data | output | 1 | Serial ADPCM data, MSB first |
| ser_oe | output | 1 | Output enable / data valid (tristate model) |

## Verification
The bench changes `enc_mode`, `pack_sel` and `ch_codes` right after every frame strobe. A design that samples them continuously would therefore mix widths or codes within a frame.

Packed modes are run with both select values, and the unselected slot is checked for a low enable. A design that ignores the select, or drives both slots, fails that check.

In 24 kbit/s frames, the fourth bit of each nibble must be 0. A design that leaks code bit 0 into that position shows a mismatch.

A shortened slot is followed by a full one, which catches a bit counter that does not restart at a fresh enable. Randomised frames across all eight codes cover the disable and reset codes and the switching between 32 and 24 kbit/s from frame to frame.

// File: rtl/adpcm_pack_pkg.sv
`timescale 1ns/1ps
package adpcm_pack_pkg;

    typedef enum logic [2:0] {
        MD_R32     = 3'd0,
        MD_R24     = 3'd1,
        MD_R16     = 3'd2,
        MD_BYP_HI  = 3'd3,
        MD_BYP_LO  = 3'd4,
        MD_PCM     = 3'd5,
        MD_ALG_RST = 3'd6,
        MD_OFF     = 3'd7
    } pack_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_SLOT1 = 2'd2,
        ST_SLOT2 = 2'd3
    } pack_st_e;

endpackage

// File: rtl/adpcm_slot_former.sv
`timescale 1ns/1ps
module adpcm_slot_former
    import adpcm_pack_pkg::*;
#(
    parameter int CODE_W  = 4,
    parameter int N_CH    = 4,
    parameter int SLOT_W  = 8,
    parameter int SLOT_ID = 0
) (
    input  pack_mode_e               mode,
    input  logic                     sel,
    input  logic [N_CH*CODE_W-1:0]   codes,
    output logic [SLOT_W-1:0]        octet,
    output logic                     active
);
    localparam int  PAIR_LO = 2 * SLOT_ID;
    localparam int  PAIR_HI = 2 * SLOT_ID + 1;
    localparam int  PACK_W  = SLOT_W / N_CH;
    localparam logic MY_SEL = (SLOT_ID != 0);

    logic [CODE_W-1:0] word_a, word_b;
    logic [CODE_W-1:0] trim_a, trim_b;
    logic [SLOT_W-1:0] packed_oct;

    always_comb begin
        word_a = codes[PAIR_LO*CODE_W +: CODE_W];
        word_b = codes[PAIR_HI*CODE_W +: CODE_W];
        trim_a = {word_a[CODE_W-1:1], 1'b0};
        trim_b = {word_b[CODE_W-1:1], 1'b0};
        packed_oct = '0;
        for (int ch = 0; ch < N_CH; ch++) begin
            packed_oct[SLOT_W-1-PACK_W*ch -: PACK_W] =
                codes[ch*CODE_W + CODE_W-1 -: PACK_W];
        end
    end

    always_comb begin
        octet  = '0;
        active = 1'b0;
        unique case (mode)
            MD_R32, MD_BYP_HI: begin
                octet  = {word_a, word_b};
                active = 1'b1;
            end
            MD_R24: begin
                octet  = {trim_a, trim_b};
                active = 1'b1;
            end
            MD_R16, MD_BYP_LO: begin
                octet  = packed_oct;
                active = (sel == MY_SEL);
            end
            MD_ALG_RST: begin
                octet  = '0;
                active = 1'b1;
            end
            default: begin
                octet  = '0;
                active = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/adpcm_pack_ctrl.sv
`timescale 1ns/1ps
module adpcm_pack_ctrl
    import adpcm_pack_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int N_CH   = 4,
    parameter int SLOT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fs,
    input  logic                     en1,
    input  logic                     en2,
    input  logic                     sel_in,
    input  logic [2:0]               mode_in,
    input  logic [N_CH*CODE_W-1:0]   codes_in,
    input  logic [SLOT_W-1:0]        oct1,
    input  logic                     act1,
    input  logic [SLOT_W-1:0]        oct2,
    input  logic                     act2,
    output pack_mode_e               mode_q,
    output logic                     sel_q,
    output logic [N_CH*CODE_W-1:0]   codes_q,
    output logic                     sdo,
    output logic                     oe
);
    localparam int CNT_W = $clog2(SLOT_W);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    pack_st_e         st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, idx;
    logic             sdo_d, oe_d;

    // state register and frame latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cnt_q   <= '0;
            sdo     <= 1'b0;
            oe      <= 1'b0;
            mode_q  <= MD_OFF;
            sel_q   <= 1'b0;
            codes_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            sdo   <= sdo_d;
            oe    <= oe_d;
            if (fs) begin
                mode_q  <= pack_mode_e'(mode_in);
                sel_q   <= sel_in;
                codes_q <= codes_in;
            end
        end
    end

    // next state and bit index
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        idx   = '0;
        if (fs) begin
            st_d  = ST_READY;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: st_d = ST_IDLE;
                ST_READY, ST_SLOT1, ST_SLOT2: begin
                    if (en1) begin
                        idx   = (st_q == ST_SLOT1) ? cnt_q : '0;
                        st_d  = ST_SLOT1;
                        cnt_d = idx + CNT_ONE;
                    end else if (en2) begin
                        idx   = (st_q == ST_SLOT2) ? cnt_q : '0;
                        st_d  = ST_SLOT2;
                        cnt_d = idx + CNT_ONE;
                    end else begin
                        st_d  = ST_READY;
                        cnt_d = '0;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sdo_d = 1'b0;
        oe_d  = 1'b0;
        if (!fs && st_q != ST_IDLE) begin
            if (en1) begin
                oe_d  = act1;
                sdo_d = act1 & oct1[SLOT_W-1-int'(idx)];
            end else if (en2) begin
                oe_d  = act2;
                sdo_d = act2 & oct2[SLOT_W-1-int'(idx)];
            end
        end
    end

    // R1: idle state emits nothing
    assert_idle_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs && st_q == ST_IDLE) |=> !oe);
    // R2: mode only moves at a frame strobe
    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fs |=> $stable(mode_q));
    // R4: fourth nibble position padded with zero
    assert_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs && mode_q == MD_R24 && (en1 || en2) && idx[1:0] == 2'b11) |=> !sdo);
    // R5: packed octet absent from the slot not selected
    assert_packed_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs && mode_q == MD_R16 && en1 && sel_q) |=> !oe);
    // R8: disable and PCM-bypass codes keep the output off
    assert_off_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs && (mode_q == MD_OFF || mode_q == MD_PCM)) |=> !oe);
    // R9: no strobe or frame strobe leaves the output off
    assert_gap_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fs || (!en1 && !en2)) |=> !oe);
    // R9: data is quiet while not enabled
    assert_quiet_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !sdo);

endmodule

// File: rtl/adpcm_word_packer.sv
`timescale 1ns/1ps
module adpcm_word_packer
    import adpcm_pack_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int N_CH   = 4,
    parameter int SLOT_W = 8
) (
    input  logic                     bclk,
    input  logic                     rst_n,
    input  logic                     frame_strobe,
    input  logic                     slot1_en,
    input  logic                     slot2_en,
    input  logic                     pack_sel,
    input  logic [2:0]               enc_mode,
    input  logic [N_CH*CODE_W-1:0]   ch_codes,
    output logic                     ser_data,
    output logic                     ser_oe
);
    localparam int N_SLOT = 2;

    pack_mode_e                mode_q;
    logic                      sel_q;
    logic [N_CH*CODE_W-1:0]    codes_q;
    logic [SLOT_W-1:0]         oct [N_SLOT];
    logic [N_SLOT-1:0]         act;

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        adpcm_slot_former #(
            .CODE_W  (CODE_W),
            .N_CH    (N_CH),
            .SLOT_W  (SLOT_W),
            .SLOT_ID (s)
        ) u_former (
            .mode   (mode_q),
            .sel    (sel_q),
            .codes  (codes_q),
            .octet  (oct[s]),
            .active (act[s])
        );
    end

    adpcm_pack_ctrl #(
        .CODE_W (CODE_W),
        .N_CH   (N_CH),
        .SLOT_W (SLOT_W)
    ) u_ctrl (
        .clk      (bclk),
        .rst_n    (rst_n),
        .fs       (frame_strobe),
        .en1      (slot1_en),
        .en2      (slot2_en),
        .sel_in   (pack_sel),
        .mode_in  (enc_mode),
        .codes_in (ch_codes),
        .oct1     (oct[0]),
        .act1     (act[0]),
        .oct2     (oct[1]),
        .act2     (act[1]),
        .mode_q   (mode_q),
        .sel_q    (sel_q),
        .codes_q  (codes_q),
        .sdo      (ser_data),
        .oe       (ser_oe)
    );

endmodule

// File: tb/adpcm_word_packer_test.sv
`timescale 1ns/1ps
module adpcm_word_packer_test;

    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_strobe = 1'b0;
    logic        slot1_en = 1'b0;
    logic        slot2_en = 1'b0;
    logic        pack_sel = 1'b0;
    logic [2:0]  enc_mode = 3'd0;
    logic [15:0] ch_codes = 16'h0;
    logic        ser_data, ser_oe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 bclk = ~bclk;

    adpcm_word_packer uut (
        .bclk(bclk), .rst_n(rst_n), .frame_strobe(frame_strobe),
        .slot1_en(slot1_en), .slot2_en(slot2_en), .pack_sel(pack_sel),
        .enc_mode(enc_mode), .ch_codes(ch_codes),
        .ser_data(ser_data), .ser_oe(ser_oe)
    );

    // expected {oe, data} for one bit
    function automatic logic [1:0] exp_bit(int md, bit sel, logic [15:0] c, int slot, int idx);
        logic [3:0] w0, w1, w2, w3;
        logic [7:0] oct;
        bit act;
        w0 = c[3:0]; w1 = c[7:4]; w2 = c[11:8]; w3 = c[15:12];
        oct = 8'h00; act = 0;
        case (md)
            0, 3: begin oct = slot ? {w2, w3} : {w0, w1}; act = 1; end
            1: begin
                oct = slot ? {w2[3:1], 1'b0, w3[3:1], 1'b0}
                           : {w0[3:1], 1'b0, w1[3:1], 1'b0};
                act = 1;
            end
            2, 4: begin
                oct = {w0[3:2], w1[3:2], w2[3:2], w3[3:2]};
                act = (sel == (slot != 0));
            end
            6: begin oct = 8'h00; act = 1; end
            default: begin oct = 8'h00; act = 0; end
        endcase
        return {act, act & oct[7-idx]};
    endfunction

    function automatic string tag_of(int md);
        case (md)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3, 4: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(string tag, logic [1:0] got, logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got oe/data=%b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // shift one slot of len bits, then one idle cycle
    task automatic run_slot(int slot, int len, int md, bit sel, logic [15:0] c, string tag);
        for (int i = 0; i < len; i++) begin
            @(negedge bclk);
            slot1_en = (slot == 0);
            slot2_en = (slot == 1);
            @(posedge bclk); #1;
            chk(tag, {ser_oe, ser_data}, exp_bit(md, sel, c, slot, i % 8));
        end
        @(negedge bclk);
        slot1_en = 1'b0;
        slot2_en = 1'b0;
        @(posedge bclk); #1;
        chk("R9", {ser_oe, ser_data}, 2'b00);
    endtask

    task automatic start_frame(int md, bit sel, logic [15:0] c, int md_after, logic [15:0] c_after);
        @(negedge bclk);
        frame_strobe = 1'b1;
        enc_mode = md[2:0];
        pack_sel = sel;
        ch_codes = c;
        @(posedge bclk); #1;
        chk("R9", {ser_oe, ser_data}, 2'b00);
        @(negedge bclk);
        frame_strobe = 1'b0;
        enc_mode = md_after[2:0];   // R2: ignored until next strobe
        pack_sel = ~sel;
        ch_codes = c_after;         // R10: ignored until next strobe
    endtask

    task automatic full_frame(int md, bit sel, logic [15:0] c, int md_after, logic [15:0] c_after);
        string t;
        t = tag_of(md);
        start_frame(md, sel, c, md_after, c_after);
        run_slot(0, 8, md, sel, c, {t, "/R2/R10"});
        run_slot(1, 8, md, sel, c, {t, "/R2/R10"});
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge bclk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240));
        repeat (3) @(posedge bclk);
        #1;
        chk("R1", {ser_oe, ser_data}, 2'b00);
        @(negedge bclk);
        rst_n = 1'b1;
        // R1: enables before any frame strobe emit nothing
        run_slot(0, 8, 7, 0, 16'h0, "R1");
        run_slot(1, 8, 7, 0, 16'h0, "R1");

        // directed: each mode code
        full_frame(0, 0, 16'hA5C3, 1, 16'h0F0F);   // R3
        full_frame(1, 0, 16'hFFFF, 0, 16'h1234);   // R4 pad must stay 0
        full_frame(0, 0, 16'h1357, 1, 16'hFFFF);   // R3 back to 32k frame by frame
        full_frame(2, 0, 16'h9E6B, 2, 16'h0000);   // R5 slot 1
        full_frame(2, 1, 16'h9E6B, 2, 16'h0000);   // R5 slot 2
        full_frame(3, 1, 16'h4D2C, 0, 16'h0000);   // R6
        full_frame(4, 1, 16'hC63A, 2, 16'hFFFF);   // R6 packed bypass
        full_frame(6, 0, 16'hFFFF, 0, 16'hFFFF);   // R7
        full_frame(7, 0, 16'hFFFF, 0, 16'hFFFF);   // R8
        full_frame(5, 1, 16'hFFFF, 0, 16'hFFFF);   // R8

        // R9: short slot then fresh slot restarts at bit 7
        start_frame(0, 0, 16'h8E71, 0, 16'h0000);
        run_slot(0, 3, 0, 0, 16'h8E71, "R9");
        run_slot(0, 8, 0, 0, 16'h8E71, "R9");
        run_slot(1, 8, 0, 0, 16'h8E71, "R3");

        // random frames across all codes
        for (int f = 0; f < 60; f++) begin
            int md, md2;
            logic [15:0] c, c2;
            bit s;
            md  = int'($urandom % 8);
            md2 = int'($urandom % 8);
            c   = 16'($urandom);
            c2  = 16'($urandom);
            s   = 1'($urandom);
            full_frame(md, s, c, md2, c2);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule